// File: doc/BRIEF.md
# Robbed-Bit Signaling Reinsertion Unit

This unit sits on the receive serial path after the elastic store. It rewrites the signaling bit positions of chosen channels using a multiframe alignment that the system supplies. It does not use the alignment recovered from the line. In T1 mode the signaling sits in the least significant bit of a channel in certain frames. The unit can fill those bits with buffered ABCD signaling, or force them to one, and each choice is made per channel. With a 2.048 MHz backplane and E1 mode, the unit fills timeslot 16 with the buffered CAS nibbles. The bits that the line framing placed in the stream are kept. Because of this, T1 reinsertion can leave two copies of the signaling in one stream.

The serial stream crosses the unit one bit per beat, over a valid/ready pair with no storage. `m_valid` follows `s_valid` and `s_ready` follows `m_ready` combinationally, so back-pressure from the sink reaches the source in the same cycle. Data is transferred only in a cycle where both valid and ready are high. The position inside the frame and the multiframe moves forward only on such a transfer. The multiframe sync travels with the data bit it marks.

Top module: `rbs_reinsert`

## Requirements
- R1: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in every cycle. `m_data` is derived combinationally from the current beat. The stream position advances only on a beat (`s_valid` and `m_ready` both high), and it holds through stalls.
- R2: A beat with `s_mfsync` high is the first bit of the first frame of a multiframe, and the count continues from there. From reset until the first such beat, `m_data` equals `s_data` whatever the masks are.
- R3: With `bp_2048` low a frame is 193 bits. Bit 0 of the frame is the framing bit. Bit k (1 to 8, sent MSB first) of channel c sits at 1+8(c-1)+(k-1). With `bp_2048` high a frame is 256 bits, with slot s in bits 8s to 8s+7. T1 channel c uses slot c, and slots 0 and 25 to 31 are never changed.
- R4: T1 with `esf_mode` low uses a 12-frame multiframe. Bit 8 of a channel in frame 6 carries A (`sig_abcd[4(c-1)+3]`) and in frame 12 carries B (`sig_abcd[4(c-1)+2]`). That bit is replaced when `reins_sel[c-1]` and `es_en` are both high.
- R5: T1 with `esf_mode` high uses a 24-frame multiframe. Bit 8 in frames 6, 12, 18 and 24 carries A, B, C and D (bits 3, 2, 1, 0 of the channel's nibble), under the same select rule as R4.
- R6: Every bit that R4, R5, R7 and R9 do not name leaves unchanged. This includes the signaling bits placed at the line-framing positions.
- R7: In T1 mode, when `ones_sel[c-1]` is high, the bits named in R4 and R5 are forced to 1 regardless of `es_en`. This takes precedence over reinsertion.
- R8: With `es_en` low, no reinsertion takes place in either mode.
- R9: E1 with `bp_2048` high uses a 16-frame multiframe, numbered 0 to 15. In frame n from 1 to 15, bits 1 to 4 of slot 16 are replaced by the ABCD of channel n, and bits 5 to 8 by the ABCD of channel n+15. Each half has its own `reins_sel` bit and needs `es_en`. Slot 16 of frame 0 is left unchanged, and `ones_sel` has no effect.
- R10: E1 with `bp_2048` low passes every bit unchanged.
- R11: Reset clears the position and the alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e1_mode | input | 1 | 1 = E1, 0 = T1 |
| bp_2048 | input | 1 | 1 = 256-bit backplane frame, 0 = 193-bit |
| es_en | input | 1 | Elastic store in use; allows reinsertion |
| esf_mode | input | 1 | T1: 1 = 24-frame, 0 = 12-frame multiframe |
| reins_sel | input | NCH | Per-channel reinsertion select, bit c-1 for channel c |
| ones_sel | input | NCH | Per-channel T1 force-to-one select |
| sig_abcd | input | 4*NCH | Buffered ABCD per channel, nibble c-1, A in the top bit |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | 1 | Input serial bit |
| s_mfsync | input | 1 | Marks the beat as multiframe start |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink ready |
| m_data | output | 1 | Output serial bit |

## Verification
The hardest case to reach from the ports is a realignment in the middle of a multiframe, made while beats are stalling. A sync that arrives with a stalled beat or an idle bus must not move the count. After such a realignment, the C and D frames of ESF must land on the new grid and not the old one. The stimulus mixes random valid and ready gaps with random masks in which channels have both force and reinsert set. It sends a first sync at an arbitrary bit, then consistent syncs at each multiframe start, plus one deliberately misplaced resync. It also raises sync on beats that are not transferred.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int BPOS_W    = 9;
  localparam int FRM_W     = 5;
  localparam int NARROW_FL = 193;
  localparam int WIDE_FL   = 256;
  localparam int D4_MF     = 12;
  localparam int ESF_MF    = 24;
  localparam int E1_MF     = 16;
  localparam int T1_CH     = 24;
  localparam int CAS_SLOT  = 16;
  localparam int E1_HALF   = 15;
  localparam int NIB       = 4;
  typedef logic [BPOS_W-1:0] bpos_t;
  typedef logic [FRM_W-1:0]  frm_t;
endpackage

// File: rtl/rsr_pos_track.sv
module rsr_pos_track
  import rsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  sync,
  input  bpos_t flen,
  input  frm_t  mflen,
  output bpos_t cur_bpos,
  output frm_t  cur_frm,
  output logic  cur_aligned,
  output bpos_t bpos_q,
  output frm_t  frm_q
);
  logic aligned_q;

  // a sync beat is position zero of frame zero
  assign cur_bpos    = sync ? '0 : bpos_q;
  assign cur_frm     = sync ? '0 : frm_q;
  assign cur_aligned = sync | aligned_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpos_q    <= '0;
      frm_q     <= '0;
      aligned_q <= 1'b0;
    end else if (beat) begin
      aligned_q <= cur_aligned;
      if (cur_bpos >= flen - 1'b1) begin
        bpos_q <= '0;
        frm_q  <= (cur_frm >= mflen - 1'b1) ? '0 : cur_frm + 1'b1;
      end else begin
        bpos_q <= cur_bpos + 1'b1;
        frm_q  <= cur_frm;
      end
    end
  end
endmodule

// File: rtl/rsr_sig_select.sv
module rsr_sig_select
  import rsr_pkg::*;
#(
  parameter int NCH = 30
) (
  input  logic              aligned,
  input  bpos_t             bpos,
  input  frm_t              frm,
  input  logic              e1_mode,
  input  logic              bp_2048,
  input  logic              es_en,
  input  logic              esf_mode,
  input  logic [NCH-1:0]    reins_sel,
  input  logic [NCH-1:0]    ones_sel,
  input  logic [NCH*NIB-1:0] sig_abcd,
  output logic              ovr,
  output logic              ovr_val,
  output logic              force_hit
);
  int p, f, slot, bitn, ech, rb_idx;
  logic rb_hit;

  always_comb begin
    p = int'(bpos);
    f = int'(frm);
    slot = -1;
    bitn = 0;
    ech = 0;
    rb_hit = 1'b0;
    rb_idx = 0;
    ovr = 1'b0;
    ovr_val = 1'b0;
    force_hit = 1'b0;
    // map bit position to slot and bit inside slot
    if (bp_2048) begin
      slot = p / 8;
      bitn = p % 8;
    end else if (p != 0) begin
      slot = (p - 1) / 8 + 1;
      bitn = (p - 1) % 8;
    end
    // robbed-bit frames on the user grid
    case (f)
      5:  begin rb_hit = 1'b1;     rb_idx = 0; end
      11: begin rb_hit = 1'b1;     rb_idx = 1; end
      17: begin rb_hit = esf_mode; rb_idx = 2; end
      23: begin rb_hit = esf_mode; rb_idx = 3; end
      default: begin rb_hit = 1'b0; rb_idx = 0; end
    endcase
    if (aligned && !e1_mode) begin
      if (slot >= 1 && slot <= T1_CH && slot <= NCH && bitn == 7 && rb_hit) begin
        if (ones_sel[slot-1]) begin
          ovr = 1'b1;
          ovr_val = 1'b1;
          force_hit = 1'b1;
        end else if (es_en && reins_sel[slot-1]) begin
          ovr = 1'b1;
          ovr_val = sig_abcd[(slot-1)*NIB + 3 - rb_idx];
        end
      end
    end else if (aligned && bp_2048 && es_en) begin
      if (slot == CAS_SLOT && f >= 1 && f <= E1_HALF) begin
        ech = (bitn < NIB) ? f : f + E1_HALF;
        if (ech <= NCH && reins_sel[ech-1]) begin
          ovr = 1'b1;
          ovr_val = sig_abcd[(ech-1)*NIB + 3 - (bitn % NIB)];
        end
      end
    end
  end
endmodule

// File: rtl/rbs_reinsert.sv
module rbs_reinsert
  import rsr_pkg::*;
#(
  parameter int NCH = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               e1_mode,
  input  logic               bp_2048,
  input  logic               es_en,
  input  logic               esf_mode,
  input  logic [NCH-1:0]     reins_sel,
  input  logic [NCH-1:0]     ones_sel,
  input  logic [NCH*NIB-1:0] sig_abcd,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic               s_data,
  input  logic               s_mfsync,
  output logic               m_valid,
  input  logic               m_ready,
  output logic               m_data
);
  localparam bpos_t FL_N = bpos_t'(NARROW_FL);
  localparam bpos_t FL_W = bpos_t'(WIDE_FL);

  logic  beat, aligned, ovr, ovr_val, force_hit;
  bpos_t flen, cur_bpos, trk_bpos;
  frm_t  mflen, cur_frm, trk_frm;

  assign beat    = s_valid & m_ready;
  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign flen    = bp_2048 ? FL_W : FL_N;
  assign mflen   = e1_mode ? frm_t'(E1_MF) : (esf_mode ? frm_t'(ESF_MF) : frm_t'(D4_MF));

  rsr_pos_track u_trk (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sync(s_mfsync),
    .flen(flen), .mflen(mflen),
    .cur_bpos(cur_bpos), .cur_frm(cur_frm), .cur_aligned(aligned),
    .bpos_q(trk_bpos), .frm_q(trk_frm)
  );

  rsr_sig_select #(.NCH(NCH)) u_sel (
    .aligned(aligned), .bpos(cur_bpos), .frm(cur_frm),
    .e1_mode(e1_mode), .bp_2048(bp_2048), .es_en(es_en), .esf_mode(esf_mode),
    .reins_sel(reins_sel), .ones_sel(ones_sel), .sig_abcd(sig_abcd),
    .ovr(ovr), .ovr_val(ovr_val), .force_hit(force_hit)
  );

  assign m_data = ovr ? ovr_val : s_data;
endmodule

// File: rtl/rsr_chk.sv
module rsr_chk
  import rsr_pkg::*;
#(
  parameter int NCH = 30
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           s_ready,
  input logic           m_valid,
  input logic           m_ready,
  input logic           s_data,
  input logic           m_data,
  input logic           s_mfsync,
  input logic           e1_mode,
  input logic           bp_2048,
  input logic           es_en,
  input logic [NCH-1:0] ones_sel,
  input bpos_t          trk_bpos,
  input frm_t           trk_frm,
  input logic           force_hit
);
  p_flow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid == s_valid) && (s_ready == m_ready));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && m_ready) |=> $stable(trk_bpos) && $stable(trk_frm));

  p_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && m_ready && s_mfsync) |=> (trk_bpos == bpos_t'(1)) && (trk_frm == '0));

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_hit |-> m_data);

  p_no_es_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!es_en && ones_sel == '0) |-> (m_data == s_data));

  p_e1_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_mode && !bp_2048) |-> (m_data == s_data));
endmodule

bind rbs_reinsert rsr_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .s_data(s_data), .m_data(m_data),
  .s_mfsync(s_mfsync), .e1_mode(e1_mode), .bp_2048(bp_2048), .es_en(es_en),
  .ones_sel(ones_sel), .trk_bpos(trk_bpos), .trk_frm(trk_frm), .force_hit(force_hit)
);

// File: tb/test_rbs_reinsert.sv
module test_rbs_reinsert;
  localparam int NCH = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic e1_mode = 0, bp_2048 = 0, es_en = 0, esf_mode = 0;
  logic [NCH-1:0] reins_sel = '0, ones_sel = '0;
  logic [NCH*4-1:0] sig_abcd = '0;
  logic s_valid = 0, s_data = 0, s_mfsync = 0, m_ready = 0;
  logic s_ready, m_valid, m_data;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model of the position
  int mb, mf;
  bit mal;

  always #4 clk = ~clk;

  rbs_reinsert #(.NCH(NCH)) i_rbs_reinsert (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .bp_2048(bp_2048),
    .es_en(es_en), .esf_mode(esf_mode), .reins_sel(reins_sel),
    .ones_sel(ones_sel), .sig_abcd(sig_abcd), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_mfsync(s_mfsync),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic int flen_f();
    return bp_2048 ? 256 : 193;
  endfunction

  function automatic int mflen_f();
    return e1_mode ? 16 : (esf_mode ? 24 : 12);
  endfunction

  // expected output bit from the requirements
  function automatic logic exp_bit(input bit al, input int p, input int f,
                                   input logic din, output string tag);
    int slot, b, ch, idx;
    tag = "R6";
    if (!al) begin tag = "R2"; return din; end
    if (e1_mode && !bp_2048) begin tag = "R10"; return din; end
    if (bp_2048) begin slot = p / 8; b = p % 8; end
    else if (p == 0) return din;
    else begin slot = (p - 1) / 8 + 1; b = (p - 1) % 8; end
    if (!e1_mode) begin
      if (bp_2048 && (slot == 0 || slot > 24)) begin tag = "R3"; return din; end
      idx = -1;
      if (f == 5) idx = 0;
      else if (f == 11) idx = 1;
      else if (esf_mode && f == 17) idx = 2;
      else if (esf_mode && f == 23) idx = 3;
      if (b != 7 || idx < 0) return din;
      ch = slot;
      if (ones_sel[ch-1]) begin tag = "R7"; return 1'b1; end
      if (!reins_sel[ch-1]) return din;
      if (!es_en) begin tag = "R8"; return din; end
      tag = esf_mode ? "R5" : "R4";
      return sig_abcd[(ch-1)*4 + 3 - idx];
    end
    if (slot != 16) return din;
    tag = "R9";
    if (f == 0) return din;
    ch = (b < 4) ? f : f + 15;
    if (!reins_sel[ch-1]) return din;
    if (!es_en) begin tag = "R8"; return din; end
    return sig_abcd[(ch-1)*4 + 3 - (b % 4)];
  endfunction

  task automatic run_cfg(input bit e1, input bit bp, input bit es, input bit esf,
                         input int ncyc);
    int first_sync = 300 + int'($urandom % 200);
    int resync = ncyc / 2;
    @(negedge clk);
    rst_n = 1'b0;
    e1_mode = e1; bp_2048 = bp; es_en = es; esf_mode = esf;
    reins_sel = NCH'({$urandom, $urandom});
    ones_sel  = NCH'({$urandom, $urandom});
    for (int k = 0; k < NCH; k++) sig_abcd[k*4 +: 4] = 4'($urandom);
    s_valid = 1'b1; m_ready = 1'b0; s_mfsync = 1'b0; s_data = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mb = 0; mf = 0; mal = 0;
    #1;
    chk("R11", m_valid, 1'b1);
    chk("R11", s_ready, 1'b0);
    for (int c = 0; c < ncyc; c++) begin
      logic sv, mr, sy, dv, ex;
      int cp, cf;
      string tg;
      @(negedge clk);
      sv = ($urandom % 5) != 0;
      mr = ($urandom % 5) != 0;
      dv = 1'($urandom);
      sy = 1'b0;
      if (c == first_sync || c == resync) begin sv = 1; mr = 1; sy = 1; end
      else if (!sv) sy = ($urandom % 8) == 0;
      else if (mal && mb == 0 && mf == 0) sy = 1'b1;
      s_valid = sv; m_ready = mr; s_data = dv; s_mfsync = sy;
      #3;
      chk("R1", m_valid, sv);
      chk("R1", s_ready, mr);
      cp = sy ? 0 : mb;
      cf = sy ? 0 : mf;
      if (sv) begin
        ex = exp_bit(mal | sy, cp, cf, dv, tg);
        chk(tg, m_data, ex);
      end
      if (sv && mr) begin
        mal = mal | sy;
        if (cp == flen_f() - 1) begin
          mb = 0;
          mf = (cf >= mflen_f() - 1) ? 0 : cf + 1;
        end else begin
          mb = cp + 1;
          mf = cf;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    run_cfg(0, 0, 1, 0, 12000);  // R4 narrow frame
    run_cfg(0, 1, 1, 0, 10000);  // R4 R3 wide frame
    run_cfg(0, 1, 1, 1, 25000);  // R5
    run_cfg(0, 0, 0, 1, 18000);  // R8 R7
    run_cfg(1, 1, 1, 0, 15000);  // R9
    run_cfg(1, 1, 0, 0, 6000);   // R8 in E1
    run_cfg(1, 0, 1, 0, 3000);   // R10
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule